// File: doc/BRIEF.md
# Streaming radix-2 delay-feedback butterfly stage

This block is one pipeline stage of a streaming fast Fourier transform. It takes one complex sample per valid clock and emits one complex sample per valid clock. Samples are grouped into blocks of 2·DEPTH. During the first DEPTH samples of a block, each incoming sample is parked in a feedback delay line. At the same time, the value that leaves that line goes to the output. During the last DEPTH samples, each new sample x[n+DEPTH] meets its partner x[n] at the head of the delay line. The stage then outputs the sum x[n] + x[n+DEPTH] and writes the difference x[n] − x[n+DEPTH] back into the line. That difference leaves the stage during the first half of the next block.

A build parameter selects one of two butterfly flavours. The plain flavour only adds and subtracts. The rotating flavour also multiplies some differences by −j, which turns (a + jb) into (b − ja). It does this by swapping the real and imaginary parts and negating one of them, with no multiplier. Only the differences formed in the second block of each pair of blocks are rotated, that is, in the last quarter of a 4·DEPTH control period. Outputs are one bit wider than inputs, so neither the sum nor the difference can overflow. Cascading stages with DEPTH = 32, 16, …, 1 gives a 64-point transform, with general twiddle multiplication placed between stages.

Top module: `sdf_bfly_stage`

## Requirements
- R1: After reset, out_vld is 0, out_re and out_im are 0, and the delay line holds zeros, so the first DEPTH outputs of a stream are 0 + j0.
- R2: out_vld in any cycle equals in_vld of the previous cycle. Each output sample belongs to the input sample accepted one clock earlier.
- R3: For an input at position p < DEPTH within its block of 2·DEPTH valid samples, the output is the difference stored by the previous block at the same position p (zero in the first block).
- R4: For an input x[k] at position p ≥ DEPTH, the output is x[k−DEPTH] + x[k], exact in DATA_W+1 signed bits.
- R5: The difference x[k−DEPTH] − x[k] formed at position p ≥ DEPTH appears at the output exactly 2·DEPTH valid samples after x[k−DEPTH] entered.
- R6: With ROT_EN=1, a difference formed in an odd-numbered block (valid-sample counter in its last quarter of 4·DEPTH) is output as (b − ja) for difference a + jb. Differences from even blocks, and all differences when ROT_EN=0, are output unchanged.
- R7: While in_vld is 0, the sample counter, the delay line and the output data hold, out_vld is 0, and in_re/in_im have no effect on any later output.
- R8: The block position is counted in valid samples only, wraps every 2·DEPTH samples (4·DEPTH for the rotation choice), and DEPTH must be a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample valid |
| in_re | input | DATA_W | Input real part, signed |
| in_im | input | DATA_W | Input imaginary part, signed |
| out_vld | output | 1 | Output sample valid |
| out_re | output | DATA_W+1 | Output real part, signed |
| out_im | output | DATA_W+1 | Output imaginary part, signed |

## Verification
Each output is due exactly one clock after its input is accepted. The bench drives inputs on the falling edge and checks the registered output on the next falling edge. It pairs each output with a running index of accepted inputs, so idle cycles never shift that pairing. A sum is due DEPTH samples after its first operand entered. A stored difference is due 2·DEPTH samples after it. The bench computes both from its own record of the stream, counted in valid samples rather than clocks. Idle cycles carry junk data. The bench checks that out_vld drops one clock after each idle cycle and that the junk never reaches a later output.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    typedef enum logic {
        SDF_PASS = 1'b0,
        SDF_BFLY = 1'b1
    } sdf_phase_e;

endpackage

// File: rtl/sdf_ctrl.sv
module sdf_ctrl #(
    parameter int DEPTH  = 4,
    parameter int ROT_EN = 1,
    localparam int LOG_D = $clog2(DEPTH),
    localparam int CW    = LOG_D + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    advance,
    output logic [CW-1:0]           cnt,
    output sdf_pkg::sdf_phase_e     phase,
    output logic                    rot
);
    import sdf_pkg::*;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign phase = st_q.cnt[LOG_D] ? SDF_BFLY : SDF_PASS;

    generate
        if (ROT_EN != 0) begin : g_rot
            // last quarter of the 4*DEPTH period
            assign rot = st_q.cnt[LOG_D+1] & st_q.cnt[LOG_D];
        end else begin : g_norot
            assign rot = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sdf_delay_line.sv
module sdf_delay_line #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic signed [WIDTH-1:0] din_re,
    input  logic signed [WIDTH-1:0] din_im,
    output logic signed [WIDTH-1:0] head_re,
    output logic signed [WIDTH-1:0] head_im
);
    typedef struct packed {
        logic signed [WIDTH-1:0] re;
        logic signed [WIDTH-1:0] im;
    } cplx_t;

    cplx_t line_d [DEPTH];
    cplx_t line_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_tap
            always_comb begin
                line_d[i] = line_q[i];
                if (shift_en) begin
                    if (i == 0) begin
                        line_d[i].re = din_re;
                        line_d[i].im = din_im;
                    end else begin
                        line_d[i] = line_q[(i == 0) ? 0 : i-1];
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    line_q[i] <= '0;
                end else begin
                    line_q[i] <= line_d[i];
                end
            end
        end
    endgenerate

    assign head_re = line_q[DEPTH-1].re;
    assign head_im = line_q[DEPTH-1].im;

endmodule

// File: rtl/sdf_bfly_core.sv
module sdf_bfly_core #(
    parameter int DATA_W = 8,
    localparam int OW    = DATA_W + 1
) (
    input  sdf_pkg::sdf_phase_e     phase,
    input  logic                    rot,
    input  logic signed [DATA_W-1:0] x_re,
    input  logic signed [DATA_W-1:0] x_im,
    input  logic signed [OW-1:0]    head_re,
    input  logic signed [OW-1:0]    head_im,
    output logic signed [OW-1:0]    out_re,
    output logic signed [OW-1:0]    out_im,
    output logic signed [OW-1:0]    wr_re,
    output logic signed [OW-1:0]    wr_im
);
    import sdf_pkg::*;

    logic signed [OW-1:0] xw_re, xw_im;
    logic signed [OW-1:0] sum_re, sum_im;
    logic signed [OW-1:0] dif_re, dif_im;

    assign xw_re  = {x_re[DATA_W-1], x_re};
    assign xw_im  = {x_im[DATA_W-1], x_im};
    assign sum_re = head_re + xw_re;
    assign sum_im = head_im + xw_im;
    assign dif_re = head_re - xw_re;
    assign dif_im = head_im - xw_im;

    always_comb begin
        if (phase == SDF_BFLY) begin
            out_re = sum_re;
            out_im = sum_im;
            if (rot) begin
                wr_re = dif_im;
                wr_im = -dif_re;
            end else begin
                wr_re = dif_re;
                wr_im = dif_im;
            end
        end else begin
            out_re = head_re;
            out_im = head_im;
            wr_re  = xw_re;
            wr_im  = xw_im;
        end
    end

endmodule

// File: rtl/sdf_bfly_stage.sv
module sdf_bfly_stage #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int ROT_EN = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_vld,
    input  logic signed [DATA_W-1:0]  in_re,
    input  logic signed [DATA_W-1:0]  in_im,
    output logic                      out_vld,
    output logic signed [DATA_W:0]    out_re,
    output logic signed [DATA_W:0]    out_im
);
    import sdf_pkg::*;

    localparam int OW = DATA_W + 1;
    localparam int CW = $clog2(DEPTH) + 2;

    typedef struct packed {
        logic                 vld;
        logic signed [OW-1:0] re;
        logic signed [OW-1:0] im;
    } out_t;

    logic [CW-1:0]        cnt_q;
    sdf_phase_e           phase;
    logic                 rot;
    logic signed [OW-1:0] head_re, head_im;
    logic signed [OW-1:0] nxt_re, nxt_im;
    logic signed [OW-1:0] wr_re, wr_im;

    out_t o_d, o_q;

    sdf_ctrl #(.DEPTH(DEPTH), .ROT_EN(ROT_EN)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(in_vld),
        .cnt    (cnt_q),
        .phase  (phase),
        .rot    (rot)
    );

    sdf_bfly_core #(.DATA_W(DATA_W)) u_core (
        .phase  (phase),
        .rot    (rot),
        .x_re   (in_re),
        .x_im   (in_im),
        .head_re(head_re),
        .head_im(head_im),
        .out_re (nxt_re),
        .out_im (nxt_im),
        .wr_re  (wr_re),
        .wr_im  (wr_im)
    );

    sdf_delay_line #(.WIDTH(OW), .DEPTH(DEPTH)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(in_vld),
        .din_re  (wr_re),
        .din_im  (wr_im),
        .head_re (head_re),
        .head_im (head_im)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = in_vld;
        if (in_vld) begin
            o_d.re = nxt_re;
            o_d.im = nxt_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_vld = o_q.vld;
    assign out_re  = o_q.re;
    assign out_im  = o_q.im;

endmodule

// File: rtl/sdf_stage_chk.sv
module sdf_stage_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int OW    = DATA_W + 1,
    localparam int CW    = $clog2(DEPTH) + 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_vld,
    input logic signed [DATA_W-1:0] in_re,
    input logic                     out_vld,
    input logic signed [OW-1:0]     out_re,
    input logic signed [OW-1:0]     out_im,
    input logic signed [OW-1:0]     head_re,
    input logic [CW-1:0]            cnt_q,
    input logic                     bfly,
    input logic                     rot
);
    logic seen_q;
    logic signed [OW-1:0] xw_re;

    assign xw_re = {in_re[DATA_W-1], in_re};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_VLD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (out_vld == $past(in_vld)));                                   // R2
    AST_PASS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !bfly) |=> (out_re == $past(head_re)));                        // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && bfly) |=> (out_re == $past(head_re + xw_re)));                 // R4
    AST_ROT_IN_BFLY: assert property (@(posedge clk) disable iff (!rst_n)
        rot |-> bfly);                                                            // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(cnt_q) && $stable(out_re) && $stable(out_im) && !out_vld)); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (cnt_q == $past(cnt_q) + 1'b1));                              // R8

endmodule

bind sdf_bfly_stage sdf_stage_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (in_vld),
    .in_re  (in_re),
    .out_vld(out_vld),
    .out_re (out_re),
    .out_im (out_im),
    .head_re(head_re),
    .cnt_q  (cnt_q),
    .bfly   (phase == sdf_pkg::SDF_BFLY),
    .rot    (rot)
);

// File: tb/tb_sdf_bfly_stage.sv
module tb_sdf_bfly_stage;
    localparam int DW  = 8;
    localparam int DEP = 4;
    localparam int NS  = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic signed [DW-1:0] in_re = '0, in_im = '0;
    logic out_vld, pl_vld;
    logic signed [DW:0] out_re, out_im, pl_re, pl_im;

    int xr [NS];
    int xi [NS];
    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    sdf_bfly_stage #(.DATA_W(DW), .DEPTH(DEP), .ROT_EN(1)) dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
        .out_vld(out_vld), .out_re(out_re), .out_im(out_im));

    sdf_bfly_stage #(.DATA_W(DW), .DEPTH(DEP), .ROT_EN(0)) dut_plain (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
        .out_vld(pl_vld), .out_re(pl_re), .out_im(pl_im));

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected output for accepted sample k; im selects the part
    function automatic int expv(input int k, input bit im, input bit rot_en);
        int blk, p, j, dr, di;
        blk = k / (2*DEP);
        p   = k % (2*DEP);
        if (p >= DEP) return im ? (xi[k-DEP] + xi[k]) : (xr[k-DEP] + xr[k]);
        if (blk == 0) return 0;
        j  = (blk-1)*2*DEP + p;
        dr = xr[j] - xr[j+DEP];
        di = xi[j] - xi[j+DEP];
        if (rot_en && ((blk-1) % 2 == 1)) return im ? -dr : di;
        return im ? di : dr;
    endfunction

    initial begin
        for (int n = 0; n < NS; n++) begin
            if (n < 16) begin
                xr[n] = (n % 2 == 0) ? 127 : -128;
                xi[n] = (n % 3 == 0) ? -128 : 127;
            end else if (n < 24) begin
                xr[n] = n;
                xi[n] = -n;
            end else begin
                xr[n] = int'($urandom_range(255)) - 128;
                xi[n] = int'($urandom_range(255)) - 128;
            end
        end
    end

    initial begin
        int sent, got, cyc;
        bit prev_vld;
        sent = 0; got = 0; cyc = 0; prev_vld = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_vld", int'(out_vld), 0);
        chk("R1 out_re", int'(out_re), 0);
        chk("R1 out_im", int'(out_im), 0);
        rst_n = 1'b1;
        while (got < NS) begin
            @(negedge clk);
            // R2 / R7: valid follows accepted input one clock later
            chk("R2 R7 out_vld", int'(out_vld), int'(prev_vld));
            chk("R2 plain out_vld", int'(pl_vld), int'(prev_vld));
            if (prev_vld) begin
                // R3 R4 R5 R6 (rotating) and R6 plain
                chk($sformatf("R3 R4 R5 R6 re k=%0d", got), int'(out_re), expv(got, 0, 1));
                chk($sformatf("R3 R4 R5 R6 im k=%0d", got), int'(out_im), expv(got, 1, 1));
                chk($sformatf("R6 plain re k=%0d", got), int'(pl_re), expv(got, 0, 0));
                chk($sformatf("R6 plain im k=%0d", got), int'(pl_im), expv(got, 1, 0));
                got++;
            end
            cyc++;
            // R7 R8: idle cycles with junk data, counted in valid samples only
            if (sent < NS && !(cyc % 7 == 3) && !(cyc > 60 && cyc < 66)) begin
                in_vld = 1'b1;
                in_re  = DW'(xr[sent]);
                in_im  = DW'(xi[sent]);
                sent++;
            end else begin
                in_vld = 1'b0;
                in_re  = DW'(cyc * 37);
                in_im  = DW'(-cyc * 11);
            end
            prev_vld = in_vld;
        end
        in_vld = 1'b0;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule